// File: doc/BRIEF.md
# Multi-lane I2S/TDM audio serializer

This block is a transmit-only audio serial port. It divides a fast master clock down to a bit clock. It derives a frame clock from that bit clock and shifts parallel PCM words out, MSB first, on four serial data lanes. One engine covers two framings.

- In the two-slot I2S framing, channel pairs are spread across the lanes and the data trails the frame-clock edge by one bit.
- In the TDM framing, every channel is placed on lane 0. The slot count is rounded up to 2, 4 or 8, and a one-bit frame pulse marks slot 0 with no data delay.

A frame of up to eight 32-bit words is offered on a valid/ready handshake. `in_ready` pulses once at every frame boundary. If no frame is offered at that moment, the block sends silence and records an underrun.

The configuration word has six fields: mode, channel count, word-length code, two clock-inversion bits and the half-period divider. The block copies it at each frame boundary and holds it fixed for the whole frame. An illegal configuration stops the engine at once.

Top module: `pcm_lane_serializer`

## Requirements
- R1: `cfg_err` is high exactly when the live configuration is illegal. The illegal cases are: `cfg_div` equals 0 (the bit clock would have to be faster than the master clock), `cfg_wlen` equals 0, or `cfg_chans` is outside 1..8. While the configuration is illegal, `in_ready` is low, and from the next cycle on all lanes are 0 and the engine is idle.
- R2: One bit period lasts 2*`cfg_div` master cycles. With no inversion, the bit clock is low for the first `cfg_div` cycles and high for the rest. Lane data changes only at the start of a bit period, which is the falling edge of the non-inverted bit clock.
- R3: The word-length code sets the slot width and the bits sent from each 32-bit input word:
  - 1: a 16-bit slot carrying word bits 31..16.
  - 2: a 32-bit slot carrying all 32 bits.
  - 3: a 32-bit slot carrying word bits 31..8, with the 8 low slot bits forced to zero.
- R4: I2S framing (`cfg_tdm`=0) has 2 slots per lane. The non-inverted frame clock is low for the first slot and high for the second, each one slot long. Bit period k of a frame carries stream bit k-1, where stream bit 0 is the MSB of slot 0. Bit period 0 carries the last stream bit of the previous frame.
- R5: In I2S framing, lane n sends channel 2n in slot 0 and channel 2n+1 in slot 1. Any channel index at or above `cfg_chans` is sent as zeros, so only lanes below ceil(chans/2) carry data.
- R6: In TDM framing (`cfg_tdm`=1), lane 0 sends channel s in slot s. The slot count is 8 for more than 4 channels, 4 for 3 or 4 channels, and 2 otherwise. Slots at or above `cfg_chans` are zero, and lanes 1..3 stay at 0.
- R7: In TDM framing, the non-inverted frame clock is high only during bit period 0 of each frame. That same bit period carries the MSB of channel 0.
- R8: `cfg_bclk_inv` inverts the bit clock and `cfg_fclk_inv` inverts the frame clock. The two bits act independently, and neither one moves the lane data in time.
- R9: `in_ready` is high for exactly one master cycle at each frame boundary, and also in the first cycle the engine starts. A frame is taken at that clock edge if `in_valid` is high. Channel k sits in `in_data` bits [32k+31:32k].
- R10: If `in_valid` is low while `in_ready` is high, the next frame is sent as zeros and `underrun` is set. `underrun` stays set until reset.
- R11: In reset, all lanes are 0, `underrun` is 0, and the bit clock and frame clock are 0.
- R12: Mode, channel count, word length, both inversions and the divider are copied at each frame boundary (and every cycle while idle). A change to any of them in the middle of a frame takes effect at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_tdm | input | 1 | 0 selects I2S framing, 1 selects TDM framing |
| cfg_chans | input | 4 | Channel count, 1..8 |
| cfg_wlen | input | 2 | Word-length code: 1 = 16-bit, 2 = 32-bit, 3 = 24 in 32-bit |
| cfg_bclk_inv | input | 1 | Inverts the bit clock |
| cfg_fclk_inv | input | 1 | Inverts the frame clock |
| cfg_div | input | DIV_W | Master cycles per bit-clock half period |
| in_valid | input | 1 | A frame is offered |
| in_ready | output | 1 | The frame is taken at this clock edge |
| in_data | input | 256 | Eight 32-bit left-justified words, channel 0 in the low word |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock |
| sd | output | 4 | Serial data lanes |
| underrun | output | 1 | Sticky flag: a frame boundary passed without a frame |
| cfg_err | output | 1 | The live configuration is illegal |

## Verification
The bench feeds a stream of pseudo-random frames. It runs that stream through I2S with 2, 3, 5 and 8 channels, so that lane routing and the zero fill of missing pairs show up separately. It then runs TDM with 1, 3 and 8 channels, which produces each of the three rounded slot counts. Each of the three word-length codes is used at least once, so slot width and low-byte masking can be told apart. The inversion bits are tried both alone and together. Further runs change the configuration in the middle of a frame, withhold frames, and make the configuration illegal while running, to separate per-frame latching from underrun handling and from the stop path.

// File: rtl/pcm_ser_pkg.sv
package pcm_ser_pkg;

    localparam int LANES     = 4;
    localparam int MAX_CH    = 8;
    localparam int WORD_W    = 32;
    localparam int FRAME_MAX = MAX_CH * WORD_W;
    localparam int BIT_W     = $clog2(FRAME_MAX);
    localparam int CH_W      = $clog2(MAX_CH) + 1;

    typedef enum logic [1:0] {
        WL_BAD  = 2'd0,
        WL_16   = 2'd1,
        WL_32   = 2'd2,
        WL_24   = 2'd3
    } wlen_e;

    typedef struct packed {
        logic            tdm;
        logic [CH_W-1:0] chans;
        wlen_e           wlen;
        logic            bclk_inv;
        logic            fclk_inv;
    } fmt_t;

    // slots carried per lane in one frame
    function automatic int slots_of(fmt_t f);
        if (!f.tdm)                    return 2;
        else if (f.chans > CH_W'(4))   return 8;
        else if (f.chans > CH_W'(2))   return 4;
        else                           return 2;
    endfunction

    // bit periods per slot
    function automatic int width_of(wlen_e w);
        return (w == WL_16) ? 16 : 32;
    endfunction

    // index of the final bit period of a frame
    function automatic logic [BIT_W-1:0] last_bit_of(fmt_t f);
        int n;
        n = slots_of(f) * width_of(f.wlen);
        return BIT_W'(n - 1);
    endfunction

endpackage

// File: rtl/pcm_ser_timing.sv
module pcm_ser_timing #(
    parameter int DIV_W = 8,
    parameter int BIT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] half_div,
    input  logic [BIT_W-1:0] last_bit,
    output logic             run,
    output logic             phase,
    output logic [BIT_W-1:0] bit_idx,
    output logic             frame_start
);

    typedef struct packed {
        logic             run;
        logic             ph;
        logic [DIV_W-1:0] hc;
        logic [BIT_W-1:0] bi;
    } tim_t;

    tim_t tim_d, tim_q;
    logic tick;
    logic at_last;

    assign tick    = (tim_q.hc == (half_div - 1'b1));
    assign at_last = tim_q.ph && (tim_q.bi == last_bit);

    always_comb begin
        tim_d       = tim_q;
        frame_start = 1'b0;
        if (!enable) begin
            tim_d = '0;
        end else if (!tim_q.run) begin
            tim_d       = '0;
            tim_d.run   = 1'b1;
            frame_start = 1'b1;
        end else if (tick) begin
            tim_d.hc = '0;
            if (!tim_q.ph) begin
                tim_d.ph = 1'b1;
            end else begin
                tim_d.ph = 1'b0;
                if (at_last) begin
                    tim_d.bi    = '0;
                    frame_start = 1'b1;
                end else begin
                    tim_d.bi = tim_q.bi + 1'b1;
                end
            end
        end else begin
            tim_d.hc = tim_q.hc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tim_q <= '0;
        else        tim_q <= tim_d;
    end

    assign run     = tim_q.run;
    assign phase   = tim_q.ph;
    assign bit_idx = tim_q.bi;

endmodule

// File: rtl/pcm_ser_lane.sv
module pcm_ser_lane
    import pcm_ser_pkg::*;
#(
    parameter int LANE = 0
) (
    input  fmt_t                 fmt,
    input  logic [FRAME_MAX-1:0] smp,
    input  logic [BIT_W-1:0]     idx_now,
    input  logic [BIT_W-1:0]     idx_last,
    output logic                 bit_now,
    output logic                 bit_last
);

    // selects one stream bit of this lane for a given bit index
    function automatic logic pick(fmt_t f, logic [FRAME_MAX-1:0] s, logic [BIT_W-1:0] idx);
        logic [BIT_W-1:0] slot;
        logic [4:0]       pos;
        logic [CH_W-1:0]  ch;
        logic             keep;
        int               at;
        if (f.wlen == WL_16) begin
            slot = idx >> 4;
            pos  = {1'b0, idx[3:0]};
        end else begin
            slot = idx >> 5;
            pos  = idx[4:0];
        end
        if (f.tdm) ch = CH_W'(slot);
        else       ch = CH_W'(2 * LANE) + CH_W'(slot);
        keep = (ch < f.chans)
             && (f.tdm ? (LANE == 0) : 1'b1)
             && !((f.wlen == WL_24) && (pos >= 5'd24));
        at = int'(ch[CH_W-2:0]) * WORD_W + (WORD_W - 1) - int'(pos);
        return keep & s[at];
    endfunction

    assign bit_now  = pick(fmt, smp, idx_now);
    assign bit_last = pick(fmt, smp, idx_last);

endmodule

// File: rtl/pcm_lane_serializer.sv
module pcm_lane_serializer
    import pcm_ser_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_tdm,
    input  logic [CH_W-1:0]      cfg_chans,
    input  logic [1:0]           cfg_wlen,
    input  logic                 cfg_bclk_inv,
    input  logic                 cfg_fclk_inv,
    input  logic [DIV_W-1:0]     cfg_div,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [FRAME_MAX-1:0] in_data,
    output logic                 bclk,
    output logic                 fclk,
    output logic [LANES-1:0]     sd,
    output logic                 underrun,
    output logic                 cfg_err
);

    typedef struct packed {
        fmt_t                 fmt;
        logic [DIV_W-1:0]     div;
        logic [FRAME_MAX-1:0] smp;
        logic [LANES-1:0]     carry;
        logic                 und;
    } top_t;

    top_t st_d, st_q;

    fmt_t             cfg_live;
    logic             cfg_ok;
    logic             run_w;
    logic             phase_w;
    logic [BIT_W-1:0] bit_idx;
    logic             frame_start;
    logic [BIT_W-1:0] idx_now;
    logic [BIT_W-1:0] idx_last;
    logic [LANES-1:0] bit_now;
    logic [LANES-1:0] bit_last;
    logic [5:0]       slot_w;
    logic             fclk_raw;
    logic             act_tdm;

    // live configuration and its legality
    always_comb begin
        cfg_live.tdm      = cfg_tdm;
        cfg_live.chans    = cfg_chans;
        cfg_live.wlen     = wlen_e'(cfg_wlen);
        cfg_live.bclk_inv = cfg_bclk_inv;
        cfg_live.fclk_inv = cfg_fclk_inv;
        cfg_ok = (cfg_wlen != 2'd0)
              && (cfg_chans != '0)
              && (cfg_chans <= CH_W'(MAX_CH))
              && (cfg_div != '0);
    end

    pcm_ser_timing #(
        .DIV_W (DIV_W),
        .BIT_W (BIT_W)
    ) u_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_ok),
        .half_div    (st_q.div),
        .last_bit    (last_bit_of(st_q.fmt)),
        .run         (run_w),
        .phase       (phase_w),
        .bit_idx     (bit_idx),
        .frame_start (frame_start)
    );

    // I2S trails the frame edge by one bit; TDM does not
    assign idx_now  = st_q.fmt.tdm ? bit_idx : (bit_idx - 1'b1);
    assign idx_last = last_bit_of(st_q.fmt);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            pcm_ser_lane #(
                .LANE (g)
            ) u_lane (
                .fmt      (st_q.fmt),
                .smp      (st_q.smp),
                .idx_now  (idx_now),
                .idx_last (idx_last),
                .bit_now  (bit_now[g]),
                .bit_last (bit_last[g])
            );
        end
    endgenerate

    // next state
    always_comb begin
        st_d = st_q;
        if (!run_w || frame_start) begin
            st_d.fmt = cfg_live;
            st_d.div = cfg_div;
        end
        if (frame_start) begin
            st_d.smp = in_valid ? in_data : '0;
            if (!in_valid) st_d.und = 1'b1;
            for (int l = 0; l < LANES; l++) begin
                st_d.carry[l] = (run_w && !st_q.fmt.tdm) ? bit_last[l] : 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // outputs
    assign slot_w  = 6'(width_of(st_q.fmt.wlen));
    assign act_tdm = st_q.fmt.tdm;

    always_comb begin
        if (!run_w)            fclk_raw = 1'b0;
        else if (st_q.fmt.tdm) fclk_raw = (bit_idx == '0);
        else                   fclk_raw = (bit_idx >= BIT_W'(slot_w));
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            if (!run_w)                               sd[l] = 1'b0;
            else if (!st_q.fmt.tdm && bit_idx == '0)  sd[l] = st_q.carry[l];
            else                                      sd[l] = bit_now[l];
        end
    end

    assign bclk     = phase_w ^ st_q.fmt.bclk_inv;
    assign fclk     = fclk_raw ^ st_q.fmt.fclk_inv;
    assign in_ready = frame_start;
    assign underrun = st_q.und;
    assign cfg_err  = !cfg_ok;

endmodule

// File: rtl/pcm_ser_checker.sv
module pcm_ser_checker
    import pcm_ser_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             in_valid,
    input logic             underrun,
    input logic             cfg_err,
    input logic [LANES-1:0] sd,
    input logic             run,
    input logic             ph,
    input logic             tdm,
    input logic             fclk_raw
);

    // R1: no frame is taken while the configuration is illegal
    p_err_blocks_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !in_ready);

    // R1: an illegal configuration silences every lane from the next cycle
    p_err_quiets_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> (sd == '0));

    // R2: lane data moves only where the bit period begins
    p_data_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !($past(ph) && !ph)) |-> $stable(sd));

    // R7: a new TDM frame opens with the frame pulse, an I2S frame with the low level
    p_frame_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> (tdm ? fclk_raw : !fclk_raw));

    // R6: in TDM framing only lane 0 can carry data
    p_tdm_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tdm) |-> (sd[LANES-1:1] == '0));

    // R10: a missing frame raises the flag
    p_underrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> underrun);

    // R10: the flag holds until reset
    p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

endmodule

bind pcm_lane_serializer pcm_ser_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .in_valid (in_valid),
    .underrun (underrun),
    .cfg_err  (cfg_err),
    .sd       (sd),
    .run      (run_w),
    .ph       (phase_w),
    .tdm      (act_tdm),
    .fclk_raw (fclk_raw)
);

// File: tb/sim_pcm_lane_serializer.sv
`timescale 1ns/1ps
module sim_pcm_lane_serializer;

    localparam int CLK_P = 10;
    localparam int DIV_W = 8;
    localparam int LIMIT = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_tdm = 1'b0;
    logic [3:0]   cfg_chans = 4'd2;
    logic [1:0]   cfg_wlen = 2'd1;
    logic         cfg_bclk_inv = 1'b0;
    logic         cfg_fclk_inv = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic         in_valid;
    logic         in_ready;
    logic [255:0] in_data = '0;
    logic         bclk, fclk, underrun, cfg_err;
    logic [3:0]   sd;

    logic         feed_en = 1'b0;
    logic         cmp_en = 1'b0;
    logic         acc_pend = 1'b0;
    logic [31:0]  seed = 32'h1357_9bdf;
    string        cur_req = "R4";
    int           checks = 0;
    int           errors = 0;
    int           cyc = 0;

    assign in_valid = feed_en;

    pcm_lane_serializer #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_tdm(cfg_tdm), .cfg_chans(cfg_chans),
        .cfg_wlen(cfg_wlen), .cfg_bclk_inv(cfg_bclk_inv), .cfg_fclk_inv(cfg_fclk_inv),
        .cfg_div(cfg_div), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .bclk(bclk), .fclk(fclk), .sd(sd), .underrun(underrun), .cfg_err(cfg_err)
    );

    always #(CLK_P/2) clk = ~clk;

    // ---------------- reference model ----------------
    int          m_run, m_t, m_und;
    int          m_tdm, m_chans, m_wlen, m_binv, m_finv, m_div;
    logic [31:0] m_word [8];
    logic        m_carry [4];

    function automatic int m_w();
        return (m_wlen == 1) ? 16 : 32;
    endfunction

    function automatic int m_slots();
        if (m_tdm == 0)     return 2;
        if (m_chans > 4)    return 8;
        if (m_chans > 2)    return 4;
        return 2;
    endfunction

    function automatic int m_bits();
        return m_slots() * m_w();
    endfunction

    function automatic logic m_bit(int lane, int s);
        int w, slot, pos, ch;
        w = m_w();
        slot = s / w;
        pos = s % w;
        ch = (m_tdm != 0) ? slot : 2 * lane + slot;
        if (m_tdm != 0 && lane != 0) return 1'b0;
        if (ch >= m_chans)           return 1'b0;
        if (m_wlen == 3 && pos >= 24) return 1'b0;
        return m_word[ch][31 - pos];
    endfunction

    function automatic bit live_ok();
        return (cfg_wlen != 2'd0) && (cfg_chans >= 4'd1) && (cfg_chans <= 4'd8) && (cfg_div != '0);
    endfunction

    task automatic latch_cfg();
        m_tdm = int'(cfg_tdm); m_chans = int'(cfg_chans); m_wlen = int'(cfg_wlen);
        m_binv = int'(cfg_bclk_inv); m_finv = int'(cfg_fclk_inv); m_div = int'(cfg_div);
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic compare();
        int per, k, ph, fr;
        logic [3:0] esd;
        logic eb, ef, er;
        esd = '0;
        if (m_run == 0) begin
            eb = m_binv[0]; ef = m_finv[0];
        end else begin
            per = 2 * m_div;
            k = m_t / per;
            ph = ((m_t % per) >= m_div) ? 1 : 0;
            eb = ph[0] ^ m_binv[0];
            fr = (m_tdm != 0) ? (k == 0) : (k >= m_w());
            ef = fr[0] ^ m_finv[0];
            for (int l = 0; l < 4; l++) begin
                if (m_tdm == 0 && k == 0) esd[l] = m_carry[l];
                else if (m_tdm != 0)      esd[l] = m_bit(l, k);
                else                      esd[l] = m_bit(l, k - 1);
            end
        end
        er = live_ok() && (m_run == 0 || m_t == m_bits() * 2 * m_div - 1);
        check("R2", "bclk", {31'd0, bclk}, {31'd0, eb});
        check(cur_req, "fclk", {31'd0, fclk}, {31'd0, ef});
        check(cur_req, "sd", {28'd0, sd}, {28'd0, esd});
        check("R9", "in_ready", {31'd0, in_ready}, {31'd0, er});
        check("R10", "underrun", {31'd0, underrun}, {31'd0, m_und[0]});
        check("R1", "cfg_err", {31'd0, cfg_err}, {31'd0, !live_ok()});
    endtask

    always @(posedge clk) begin
        int was;
        if (!rst_n) begin
            m_run = 0; m_t = 0; m_und = 0;
            m_tdm = 0; m_chans = 0; m_wlen = 0; m_binv = 0; m_finv = 0; m_div = 0;
            for (int c = 0; c < 8; c++) m_word[c] = '0;
            for (int l = 0; l < 4; l++) m_carry[l] = 1'b0;
        end else begin
            was = m_run;
            if (!live_ok()) begin
                if (was == 0) latch_cfg();
                m_run = 0; m_t = 0;
            end else if (was == 0 || m_t == m_bits() * 2 * m_div - 1) begin
                for (int l = 0; l < 4; l++)
                    m_carry[l] = (was != 0 && m_tdm == 0) ? m_bit(l, m_bits() - 1) : 1'b0;
                latch_cfg();
                for (int c = 0; c < 8; c++) m_word[c] = in_valid ? in_data[c*32 +: 32] : 32'd0;
                if (!in_valid) m_und = 1;
                m_run = 1; m_t = 0;
            end else begin
                m_t++;
            end
        end
        #(CLK_P/4);
        if (rst_n && cmp_en) compare();
    end

    // ---------------- frame feeder ----------------
    task automatic new_frame();
        for (int c = 0; c < 8; c++) begin
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 17);
            seed = seed ^ (seed << 5);
            in_data[c*32 +: 32] = seed;
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (acc_pend) new_frame();
        acc_pend = in_ready && in_valid && rst_n;
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog actual=%0d cycles expected=below %0d", cyc, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic set_cfg(input logic t, input int ch, input int wl,
                           input logic bi, input logic fi, input int dv);
        @(negedge clk);
        cfg_tdm = t; cfg_chans = 4'(ch); cfg_wlen = 2'(wl);
        cfg_bclk_inv = bi; cfg_fclk_inv = fi; cfg_div = DIV_W'(dv);
    endtask

    task automatic run_frames(input int n);
        int w, s;
        w = (cfg_wlen == 2'd1) ? 16 : 32;
        s = (cfg_tdm == 1'b0) ? 2 : (cfg_chans > 4) ? 8 : (cfg_chans > 2) ? 4 : 2;
        repeat (n * s * w * 2 * int'(cfg_div) + 8) @(negedge clk);
    endtask

    initial begin
        new_frame();
        // R11: reset state
        repeat (3) @(negedge clk);
        #2;
        check("R11", "sd in reset", {28'd0, sd}, 32'd0);
        check("R11", "underrun in reset", {31'd0, underrun}, 32'd0);
        check("R11", "bclk in reset", {31'd0, bclk}, 32'd0);
        check("R11", "fclk in reset", {31'd0, fclk}, 32'd0);
        check("R1", "cfg_err with zero divider", {31'd0, cfg_err}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        cur_req = "R1";
        repeat (20) @(negedge clk);
        #2;
        check("R1", "idle lanes", {28'd0, sd}, 32'd0);
        check("R1", "idle ready", {31'd0, in_ready}, 32'd0);

        feed_en = 1'b1;
        cur_req = "R4";
        set_cfg(1'b0, 2, 1, 1'b0, 1'b0, 2);
        run_frames(3);
        cur_req = "R5";
        set_cfg(1'b0, 8, 2, 1'b0, 1'b0, 2);
        run_frames(3);
        cur_req = "R3";
        set_cfg(1'b0, 5, 3, 1'b0, 1'b0, 1);
        run_frames(3);
        cur_req = "R8";
        set_cfg(1'b0, 3, 2, 1'b1, 1'b0, 2);
        run_frames(2);
        set_cfg(1'b0, 3, 1, 1'b0, 1'b1, 2);
        run_frames(2);
        set_cfg(1'b0, 4, 2, 1'b1, 1'b1, 3);
        run_frames(2);
        cur_req = "R6";
        set_cfg(1'b1, 8, 2, 1'b0, 1'b0, 1);
        run_frames(3);
        cur_req = "R7";
        set_cfg(1'b1, 3, 1, 1'b0, 1'b0, 2);
        run_frames(3);
        cur_req = "R6";
        set_cfg(1'b1, 1, 3, 1'b1, 1'b1, 3);
        run_frames(2);

        // R12: changes inside a frame wait for the boundary
        cur_req = "R12";
        set_cfg(1'b0, 4, 2, 1'b0, 1'b0, 2);
        run_frames(1);
        repeat (37) @(negedge clk);
        cfg_chans = 4'd2; cfg_fclk_inv = 1'b1; cfg_wlen = 2'd1;
        run_frames(3);
        set_cfg(1'b1, 6, 2, 1'b0, 1'b0, 1);
        repeat (50) @(negedge clk);
        cfg_tdm = 1'b0;
        run_frames(2);

        // R10: frames withheld
        cur_req = "R10";
        feed_en = 1'b0;
        run_frames(2);
        #2;
        check("R10", "underrun after missing frames", {31'd0, underrun}, 32'd1);
        feed_en = 1'b1;
        run_frames(2);
        #2;
        check("R10", "underrun still set", {31'd0, underrun}, 32'd1);

        // R1: illegal word length while running
        cur_req = "R1";
        set_cfg(1'b0, 4, 2, 1'b0, 1'b0, 2);
        repeat (100) @(negedge clk);
        cfg_wlen = 2'd0;
        repeat (3) @(negedge clk);
        #2;
        check("R1", "lanes after error", {28'd0, sd}, 32'd0);
        check("R1", "ready after error", {31'd0, in_ready}, 32'd0);
        check("R1", "cfg_err raised", {31'd0, cfg_err}, 32'd1);
        set_cfg(1'b0, 9, 2, 1'b0, 1'b0, 2);
        repeat (10) @(negedge clk);
        #2;
        check("R1", "cfg_err for nine channels", {31'd0, cfg_err}, 32'd1);
        set_cfg(1'b0, 2, 2, 1'b0, 1'b0, 1);
        run_frames(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule